// File: doc/BRIEF.md
# Debit-Limited Multi-Task Request Scheduler

This block sits between several independent producers of flash operations (for example host I/O, garbage collection and read scrubbing) and the per-chip command queues of a flash subsystem. Each producer writes requests into its own small pending buffer. A request names a target chip and carries a tag. Every cycle the scheduler picks at most one request and hands it to the chip queues.

Fairness is enforced only by capping the number of in-flight requests per producer. Each producer has a debit counter. The counter rises when one of its requests is issued and falls when a completion for that producer comes back. The cap on the counter follows from a share input, scaled by the total number of chip-queue slots. The scheduler keeps no time or virtual-clock accounting. A request whose chip queue is full is skipped in favour of that producer's next pending request or another producer. Producers are fully separate slices, so a new producer type only adds one more slice.

The issue outputs are combinational from registered state and the current `chip_full` and `share` inputs. The consumer takes an issued request in the same cycle that `iss_valid` is high.

Top module: `debit_sched`

## Requirements
- R1: After reset every debit counter is zero, no request is issued and no pending buffer reports full.
- R2: In the cycle a producer's request is issued, with no completion for that producer, its debit rises by exactly one at the next clock edge.
- R3: A completion whose task ID names a producer with nonzero debit lowers that debit by exactly one at the next clock edge, when no issue for that producer happens in the same cycle.
- R4: A producer's cap is `(share * NCHIP * CHIP_QDEPTH) >> SHIFT`, raised to 1 when that value is 0 and share is nonzero. A share of 0 gives a cap of 0, so a producer with share 0 never issues.
- R5: A producer whose debit is equal to or above its cap issues nothing, even when chip queues have room.
- R6: No request is issued to a chip whose `chip_full` bit is set. Within one producer, the oldest pending request whose chip is not full is chosen. `iss_chip` and `iss_tag` carry that request's fields.
- R7: At most one request is issued per cycle. Among eligible producers the winner is the first one found in ascending index order after the last winner, wrapping around. After reset the search starts at producer 0. An eligible producer has a pending request to a non-full chip and a debit below its cap.
- R8: When a producer issues and receives a completion in the same cycle, its debit is unchanged.
- R9: A completion naming a producer whose debit is zero raises `cpl_err` in that cycle and leaves that debit at zero, apart from any issue by that producer in the same cycle.
- R10: Each pending buffer holds `QDEPTH` requests. `req_full` is high exactly when the buffer holds that many. A push while full is dropped, and the buffer contents are unchanged apart from any issue that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_push | input | NTASK | Per-producer push strobe into its pending buffer |
| req_chip | input | NTASK*CHIP_W | Per-producer target chip of the pushed request |
| req_tag | input | NTASK*TAG_W | Per-producer tag of the pushed request |
| req_full | output | NTASK | Per-producer pending buffer is full |
| share | input | NTASK*SHARE_W | Per-producer share value |
| chip_full | input | NCHIP | Per-chip command queue has no room |
| iss_valid | output | 1 | A request is issued this cycle |
| iss_task | output | TASK_W | Producer of the issued request |
| iss_chip | output | CHIP_W | Target chip of the issued request |
| iss_tag | output | TAG_W | Tag of the issued request |
| cpl_valid | input | 1 | A completion is returned this cycle |
| cpl_task | input | TASK_W | Producer the completion belongs to |
| cpl_err | output | 1 | Completion named a producer with zero debit |
| debit | output | NTASK*DEBIT_W | Per-producer outstanding-request count |

## Verification
The main function is first tried with all producers at full share and all chips free, which exposes the round-robin order by itself. Setting chip-full bits under an oldest request shows whether the scheduler skips to a later request rather than stalling or issuing into a full queue. Small and zero shares with several pending requests separate cap enforcement and the clamp-to-one rule from plain arbitration. Completions placed in the same cycle as an issue, and completions sent to an idle producer, tell the hold rule and the error flag apart. A long random phase then mixes chip-full patterns, share changes, pushes to full buffers and completions.

// File: rtl/debit_pkg.sv
package debit_pkg;

  // Cap on a producer's in-flight count, from its share and the slot total.
  function automatic int unsigned debit_limit(input int unsigned share_v,
                                              input int unsigned slots,
                                              input int unsigned shift);
    int unsigned raw;
    raw = (share_v * slots) >> shift;
    if (share_v == 0) return 0;
    if (raw == 0) return 1;
    return raw;
  endfunction

endpackage

// File: rtl/dsched_task_queue.sv
module dsched_task_queue #(
  parameter int DEPTH  = 4,
  parameter int NCHIP  = 4,
  parameter int TAG_W  = 4,
  localparam int CHIP_W = (NCHIP > 1) ? $clog2(NCHIP) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [CHIP_W-1:0] push_chip,
  input  logic [TAG_W-1:0]  push_tag,
  input  logic [NCHIP-1:0]  chip_full,
  input  logic              pop,
  output logic              full,
  output logic              has_ready,
  output logic [CHIP_W-1:0] sel_chip,
  output logic [TAG_W-1:0]  sel_tag
);
  localparam int SEL_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CHIP_W-1:0] chip_q [DEPTH];
  logic [TAG_W-1:0]  tag_q  [DEPTH];
  logic [CNT_W-1:0]  cnt_q;
  logic [DEPTH-1:0]  ready;
  logic [SEL_W-1:0]  sel;
  logic              accept;
  logic [CNT_W-1:0]  wr_pos;

  assign full   = (cnt_q == CNT_W'(DEPTH));
  assign accept = push && !full;
  assign wr_pos = pop ? cnt_q - CNT_W'(1) : cnt_q;

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      ready[i] = (CNT_W'(i) < cnt_q) && !chip_full[chip_q[i]];
  end

  always_comb begin
    sel = '0;
    has_ready = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!has_ready && ready[i]) begin
        has_ready = 1'b1;
        sel = SEL_W'(i);
      end
    end
  end

  assign sel_chip = chip_q[sel];
  assign sel_tag  = tag_q[sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        chip_q[i] <= '0;
        tag_q[i]  <= '0;
      end
    end else begin
      if (pop) begin
        for (int i = 0; i < DEPTH - 1; i++) begin
          if (SEL_W'(i) >= sel) begin
            chip_q[i] <= chip_q[i+1];
            tag_q[i]  <= tag_q[i+1];
          end
        end
      end
      if (accept) begin
        chip_q[wr_pos] <= push_chip;
        tag_q[wr_pos]  <= push_tag;
      end
      cnt_q <= cnt_q + CNT_W'(accept) - CNT_W'(pop);
    end
  end

  // A dropped push while full never grows the occupancy.
  assert_full_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> (cnt_q <= $past(cnt_q)));

  // The arbiter only pops a slice that offered a ready request.
  assert_pop_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> has_ready);

endmodule

// File: rtl/dsched_debit.sv
module dsched_debit #(
  parameter int SHARE_W = 8,
  parameter int SLOTS   = 16,
  parameter int SHIFT   = 8,
  parameter int DEBIT_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SHARE_W-1:0] share,
  input  logic               grant,
  input  logic               cpl_hit,
  output logic [DEBIT_W-1:0] debit,
  output logic               eligible,
  output logic               err
);
  logic [DEBIT_W-1:0] limit;
  logic               dec;

  assign limit    = DEBIT_W'(debit_pkg::debit_limit(int'(share), SLOTS, SHIFT));
  assign eligible = (debit < limit);
  assign dec      = cpl_hit && (debit != '0);
  assign err      = cpl_hit && (debit == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      debit <= '0;
    end else begin
      case ({grant, dec})
        2'b10:   debit <= debit + DEBIT_W'(1);
        2'b01:   debit <= debit - DEBIT_W'(1);
        default: debit <= debit;
      endcase
    end
  end

  assert_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !cpl_hit) |=> (debit == $past(debit) + DEBIT_W'(1)));

  assert_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_hit && !grant && $past(rst_n) && debit != '0) |=> (debit == $past(debit) - DEBIT_W'(1)));

  assert_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (debit < limit));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && cpl_hit && debit != '0) |=> $stable(debit));

  assert_err_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !grant) |=> (debit == '0));

endmodule

// File: rtl/dsched_rr_arb.sv
module dsched_rr_arb #(
  parameter int N  = 3,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] gidx,
  output logic          any
);
  logic [IW-1:0] last_q;
  int            idx;

  always_comb begin
    grant = '0;
    gidx  = last_q;
    any   = 1'b0;
    idx   = 0;
    for (int k = 1; k <= N; k++) begin
      idx = int'(last_q) + k;
      if (idx >= N) idx = idx - N;
      if (!any && req[idx]) begin
        any        = 1'b1;
        grant[idx] = 1'b1;
        gidx       = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= IW'(N - 1);
    else if (any) last_q <= gidx;
  end

  assert_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_work_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |-> any);

endmodule

// File: rtl/debit_sched.sv
module debit_sched #(
  parameter int NTASK       = 3,
  parameter int NCHIP       = 4,
  parameter int CHIP_QDEPTH = 4,
  parameter int QDEPTH      = 4,
  parameter int SHARE_W     = 8,
  parameter int SHIFT       = 8,
  parameter int TAG_W       = 4,
  localparam int CHIP_W  = (NCHIP > 1) ? $clog2(NCHIP) : 1,
  localparam int TASK_W  = (NTASK > 1) ? $clog2(NTASK) : 1,
  localparam int SLOTS   = NCHIP * CHIP_QDEPTH,
  localparam int DEBIT_W = $clog2(SLOTS + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NTASK-1:0]           req_push,
  input  logic [NTASK*CHIP_W-1:0]    req_chip,
  input  logic [NTASK*TAG_W-1:0]     req_tag,
  output logic [NTASK-1:0]           req_full,
  input  logic [NTASK*SHARE_W-1:0]   share,
  input  logic [NCHIP-1:0]           chip_full,
  output logic                       iss_valid,
  output logic [TASK_W-1:0]          iss_task,
  output logic [CHIP_W-1:0]          iss_chip,
  output logic [TAG_W-1:0]           iss_tag,
  input  logic                       cpl_valid,
  input  logic [TASK_W-1:0]          cpl_task,
  output logic                       cpl_err,
  output logic [NTASK*DEBIT_W-1:0]   debit
);
  logic [NTASK-1:0]  has_ready;
  logic [NTASK-1:0]  eligible;
  logic [NTASK-1:0]  arb_req;
  logic [NTASK-1:0]  grant;
  logic [NTASK-1:0]  err_vec;
  logic [CHIP_W-1:0] sel_chip [NTASK];
  logic [TAG_W-1:0]  sel_tag  [NTASK];
  logic [TASK_W-1:0] gidx;
  logic              any;

  for (genvar t = 0; t < NTASK; t++) begin : g_task
    logic cpl_hit;
    assign cpl_hit = cpl_valid && (cpl_task == TASK_W'(t));

    dsched_task_queue #(.DEPTH(QDEPTH), .NCHIP(NCHIP), .TAG_W(TAG_W)) u_queue (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (req_push[t]),
      .push_chip (req_chip[t*CHIP_W +: CHIP_W]),
      .push_tag  (req_tag[t*TAG_W +: TAG_W]),
      .chip_full (chip_full),
      .pop       (grant[t]),
      .full      (req_full[t]),
      .has_ready (has_ready[t]),
      .sel_chip  (sel_chip[t]),
      .sel_tag   (sel_tag[t])
    );

    dsched_debit #(.SHARE_W(SHARE_W), .SLOTS(SLOTS), .SHIFT(SHIFT), .DEBIT_W(DEBIT_W)) u_debit (
      .clk      (clk),
      .rst_n    (rst_n),
      .share    (share[t*SHARE_W +: SHARE_W]),
      .grant    (grant[t]),
      .cpl_hit  (cpl_hit),
      .debit    (debit[t*DEBIT_W +: DEBIT_W]),
      .eligible (eligible[t]),
      .err      (err_vec[t])
    );
  end

  assign arb_req = has_ready & eligible;

  dsched_rr_arb #(.N(NTASK), .IW(TASK_W)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (arb_req),
    .grant (grant),
    .gidx  (gidx),
    .any   (any)
  );

  assign iss_valid = any;
  assign iss_task  = gidx;
  assign iss_chip  = sel_chip[gidx];
  assign iss_tag   = sel_tag[gidx];
  assign cpl_err   = |err_vec;

  assert_no_full_chip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> !chip_full[iss_chip]);

  assert_one_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(err_vec));

endmodule

// File: tb/sim_debit_sched.sv
module sim_debit_sched;
  localparam int NT = 3, NC = 4, CQD = 4, QD = 4, SW = 8, SH = 8, TW = 4;
  localparam int CW = 2, KW = 2, DW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NT-1:0]    req_push = '0;
  logic [NT*CW-1:0] req_chip = '0;
  logic [NT*TW-1:0] req_tag = '0;
  logic [NT-1:0]    req_full;
  logic [NT*SW-1:0] share = '0;
  logic [NC-1:0]    chip_full = '0;
  logic             iss_valid, cpl_err;
  logic [KW-1:0]    iss_task;
  logic [CW-1:0]    iss_chip;
  logic [TW-1:0]    iss_tag;
  logic             cpl_valid = 1'b0;
  logic [KW-1:0]    cpl_task = '0;
  logic [NT*DW-1:0] debit;

  always #2 clk = ~clk;

  debit_sched u0 (.clk(clk), .rst_n(rst_n), .req_push(req_push), .req_chip(req_chip),
    .req_tag(req_tag), .req_full(req_full), .share(share), .chip_full(chip_full),
    .iss_valid(iss_valid), .iss_task(iss_task), .iss_chip(iss_chip), .iss_tag(iss_tag),
    .cpl_valid(cpl_valid), .cpl_task(cpl_task), .cpl_err(cpl_err), .debit(debit));

  int errs = 0, checks = 0;
  int qc[NT][$];
  int qt[NT][$];
  int deb[NT];
  int last = NT - 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cap_of(input int s);
    int v;
    if (s == 0) return 0;
    v = (s * NC * CQD) / (1 << SH);
    return (v < 1) ? 1 : v;
  endfunction

  task automatic push(input int t, input int c, input int g);
    req_push[t] = 1'b1;
    req_chip[t*CW +: CW] = CW'(c);
    req_tag[t*TW +: TW] = TW'(g);
  endtask

  task automatic set_share(input int t, input int s);
    share[t*SW +: SW] = SW'(s);
  endtask

  task automatic complete(input int t);
    cpl_valid = 1'b1;
    cpl_task = KW'(t);
  endtask

  // One cycle: compare outputs with the model, advance the model, move to the next falling edge.
  task automatic cyc();
    int pick, pidx[NT], inc, dec;
    bit elig[NT];
    #1;
    pick = -1;
    for (int t = 0; t < NT; t++) begin
      pidx[t] = -1;
      for (int i = 0; i < qc[t].size(); i++)
        if (pidx[t] < 0 && !chip_full[qc[t][i]]) pidx[t] = i;
      elig[t] = (pidx[t] >= 0) && (deb[t] < cap_of(int'(share[t*SW +: SW])));
    end
    for (int k = 1; k <= NT; k++) begin
      int idx = (last + k) % NT;
      if (pick < 0 && elig[idx]) pick = idx;
    end
    chk("R4 R5 R7 issue valid", int'(iss_valid), int'(pick >= 0));
    if (pick >= 0) begin
      chk("R7 issue task", int'(iss_task), pick);
      chk("R6 issue chip", int'(iss_chip), qc[pick][pidx[pick]]);
      chk("R6 issue tag", int'(iss_tag), qt[pick][pidx[pick]]);
    end
    chk("R9 cpl_err", int'(cpl_err), int'(cpl_valid && deb[cpl_task] == 0));
    for (int t = 0; t < NT; t++) begin
      chk("R2 R3 R8 debit", int'(debit[t*DW +: DW]), deb[t]);
      chk("R10 req_full", int'(req_full[t]), int'(qc[t].size() == QD));
    end
    for (int t = 0; t < NT; t++) begin
      bit acc = req_push[t] && (qc[t].size() < QD);
      inc = (pick == t);
      dec = (cpl_valid && cpl_task == KW'(t) && deb[t] > 0);
      deb[t] = deb[t] + inc - dec;
      if (inc != 0) begin
        qc[t].delete(pidx[t]);
        qt[t].delete(pidx[t]);
      end
      if (acc) begin
        qc[t].push_back(int'(req_chip[t*CW +: CW]));
        qt[t].push_back(int'(req_tag[t*TW +: TW]));
      end
    end
    if (pick >= 0) last = pick;
    @(negedge clk);
    req_push = '0;
    cpl_valid = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    errs++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int t = 0; t < NT; t++) deb[t] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1 no issue", int'(iss_valid), 0);
    chk("R1 debit zero", int'(debit), 0);
    chk("R1 not full", int'(req_full), 0);
    @(negedge clk);

    // Full shares, one request per producer: round-robin order (R7)
    for (int t = 0; t < NT; t++) set_share(t, 255);
    push(0, 0, 1); push(1, 1, 2); push(2, 2, 3);
    cyc();
    repeat (3) cyc();

    // Oldest request blocked by a full chip: later one is chosen (R6)
    chip_full = 4'b0010;
    push(0, 1, 4); cyc();
    push(0, 2, 5); cyc();
    cyc();
    chip_full = 4'b0000;
    cyc();

    // Small and zero shares (R4, R5)
    set_share(1, 1);
    set_share(2, 0);
    push(1, 3, 6); push(2, 3, 7); cyc();
    push(1, 3, 8); cyc();
    repeat (2) cyc();
    complete(1); cyc();
    repeat (2) cyc();

    // Same-cycle issue and completion on one producer (R8)
    push(0, 0, 9); cyc();
    push(0, 0, 10); complete(0); cyc();
    cyc();

    // Completions to an idle producer (R9)
    complete(2); cyc();
    complete(2); cyc();
    complete(2); cyc();

    // Fill producer 2 (share 0) past its depth (R10)
    for (int n = 0; n < QD + 2; n++) begin
      push(2, n % NC, n);
      cyc();
    end
    cyc();

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      for (int t = 0; t < NT; t++) begin
        if ($urandom_range(2) == 0) push(t, $urandom_range(NC - 1), $urandom_range(15));
        if ($urandom_range(40) == 0) begin
          case ($urandom_range(4))
            0: set_share(t, 0);
            1: set_share(t, 1);
            2: set_share(t, 16);
            3: set_share(t, 64);
            default: set_share(t, 255);
          endcase
        end
      end
      chip_full = NC'($urandom_range((1 << NC) - 1));
      begin
        int ct = $urandom_range(NT - 1);
        if ((deb[ct] > 0 && $urandom_range(1) == 0) || $urandom_range(31) == 0) complete(ct);
      end
      cyc();
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule